// File: doc/BRIEF.md
# Byte-Serial 16x16 Multiplier

This block multiplies two 16-bit operands, as unsigned or as two's-complement numbers, using a single combinational 8x8 unsigned multiplier core. It reuses that core over several clock cycles. A one-cycle start strobe captures both operands and the mode. The control then feeds one byte pair per cycle to the core and adds each 16-bit partial product into a 32-bit accumulator, aligned to its byte position. The accumulator is held as four bytes, least significant first.

In signed mode, a negative operand needs a fix to the upper half of the result. The block applies this with one extra subtraction cycle per negative operand: the other operand is subtracted from accumulator bits 31:16. A `done` pulse marks the cycle in which the result is final. The result then stays on `product` until the next operation is accepted.

The block is used as a shared arithmetic resource. It trades a few cycles of latency for one narrow multiplier in place of a full 16x16 array.

Top module: `byte_serial_mul`

## Requirements
- R1: In unsigned mode (`signedMode`=0), `product` equals the 32-bit unsigned product of `opA` and `opB` in the cycle where `done` is high.
- R2: In signed mode (`signedMode`=1), `product` equals the 32-bit two's-complement product of `opA` and `opB`. This includes the extreme operands 0x8000 and 0xFFFF.
- R3: A start is accepted only while `busy` is low. A start while `busy` is high, including the `done` cycle, is ignored: it neither restarts the operation nor alters the result.
- R4: `done` is high for exactly one cycle per accepted operation, and `busy` stays high from acceptance through that cycle.
- R5: `done` rises 4 + k clock cycles after the accepting edge. k is 0 in unsigned mode and equals the number of operands with bit 15 set in signed mode.
- R6: Operands and mode are captured at acceptance. Changes to `opA`, `opB` or `signedMode` while busy do not affect the result.
- R7: While idle and no start is accepted, `product` holds its last value, including in the cycle after `done`.
- R8: After reset, `busy`, `done` and `product` are all zero.
- R9: On acceptance the accumulator is cleared, so `product` reads zero in the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe, sampled while idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse: result valid |
| product | output | 32 | Accumulated 32-bit result |

## Verification
The case that matters most is a new start strobe arriving in the same cycle as the finishing `done` pulse, while the result is still being presented. The bench provokes it by holding `startIn` high for the whole operation, including the done cycle, and changing the operands and mode mid-flight. It then requires three things: the result must match the first operands, `busy` must drop after `done`, and no second operation may begin. A second overlap is the pair of signed corrections that both fire when both operands are negative. Directed 0x8000 and 0xFFFF cases drive this overlap, and each is judged on its result value and on its cycle count.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PART,
    ST_FIXB,
    ST_FIXA,
    ST_FIN
  } bsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // capture operands, clear accumulator
    logic       addPart;  // add selected partial product
    logic [1:0] partSel;  // 0: lo*lo, 1: hi*hi, 2: lo*hiB, 3: hiA*lo
    logic       subA;     // subtract operand A from upper half
    logic       subB;     // subtract operand B from upper half
  } bsmCtl_t;

endpackage

// File: rtl/bsm_core.sv
// Combinational unsigned WxW multiplier, built as a shift-add array.
module bsm_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] rowTerm [W];
  logic [PW-1:0] runSum  [W+1];

  assign runSum[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    assign rowTerm[i]  = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    assign runSum[i+1] = runSum[i] + rowTerm[i];
  end

  assign p = runSum[W];
endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsmCtl_t           ctl,
  input  logic              signedMode,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              negA,
  output logic              negB,
  output logic [2*OP_W-1:0] product
);
  localparam int HALF  = OP_W / 2;
  localparam int RES_W = 2 * OP_W;
  localparam int NBYTE = RES_W / 8;

  logic [OP_W-1:0]        aReg, bReg;
  logic                   sgnReg;
  logic [NBYTE-1:0][7:0]  accBytes;
  logic [HALF-1:0]        coreA, coreB;
  logic [OP_W-1:0]        coreP;
  logic [RES_W-1:0]       addend;
  logic                   doSub;
  logic [RES_W-1:0]       accNext;

  bsm_core #(.W(HALF)) u_core (.a(coreA), .b(coreB), .p(coreP));

  always_comb begin
    coreA = aReg[HALF-1:0];
    coreB = bReg[HALF-1:0];
    unique case (ctl.partSel)
      2'd0: begin coreA = aReg[HALF-1:0];    coreB = bReg[HALF-1:0];    end
      2'd1: begin coreA = aReg[OP_W-1:HALF]; coreB = bReg[OP_W-1:HALF]; end
      2'd2: begin coreA = aReg[HALF-1:0];    coreB = bReg[OP_W-1:HALF]; end
      default: begin coreA = aReg[OP_W-1:HALF]; coreB = bReg[HALF-1:0]; end
    endcase
  end

  always_comb begin
    addend = '0;
    doSub  = 1'b0;
    if (ctl.addPart) begin
      unique case (ctl.partSel)
        2'd0:    addend = {{OP_W{1'b0}}, coreP};
        2'd1:    addend = {coreP, {OP_W{1'b0}}};
        default: addend = {{HALF{1'b0}}, coreP, {HALF{1'b0}}};
      endcase
    end else if (ctl.subA) begin
      addend = {aReg, {OP_W{1'b0}}};
      doSub  = 1'b1;
    end else if (ctl.subB) begin
      addend = {bReg, {OP_W{1'b0}}};
      doSub  = 1'b1;
    end
    accNext = doSub ? (accBytes - addend) : (accBytes + addend);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      sgnReg   <= 1'b0;
      accBytes <= '0;
    end else if (ctl.load) begin
      aReg     <= opA;
      bReg     <= opB;
      sgnReg   <= signedMode;
      accBytes <= '0;
    end else if (ctl.addPart || ctl.subA || ctl.subB) begin
      accBytes <= accNext;
    end
  end

  assign negA    = sgnReg & aReg[OP_W-1];
  assign negB    = sgnReg & bReg[OP_W-1];
  assign product = accBytes;
endmodule

// File: rtl/bsm_control.sv
module bsm_control
  import bsm_pkg::*;
#(
  parameter int PARTS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    negA,
  input  logic    negB,
  output bsmCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int IDX_W = $clog2(PARTS);

  bsmState_t       state, stateNext;
  logic [IDX_W-1:0] partIdx;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startIn) stateNext = ST_PART;
      ST_PART: if (partIdx == IDX_W'(PARTS - 1))
                 stateNext = negB ? ST_FIXB : (negA ? ST_FIXA : ST_FIN);
      ST_FIXB: stateNext = negA ? ST_FIXA : ST_FIN;
      ST_FIXA: stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      partIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_PART) partIdx <= partIdx + 1'b1;
      else                  partIdx <= '0;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && startIn;
    ctl.addPart = (state == ST_PART);
    ctl.partSel = 2'(partIdx);
    ctl.subA    = (state == ST_FIXB);  // B negative: remove A from top half
    ctl.subB    = (state == ST_FIXA);  // A negative: remove B from top half
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/byte_serial_mul.sv
module byte_serial_mul
  import bsm_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              signedMode,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);
  localparam int PARTS = 4;

  bsmCtl_t ctl;
  logic    negA, negB;

  bsm_control #(.PARTS(PARTS)) u_ctl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .negA(negA), .negB(negB), .ctl(ctl), .busy(busy), .done(done)
  );

  bsm_datapath #(.OP_W(OP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .signedMode(signedMode),
    .opA(opA), .opB(opB), .negA(negA), .negB(negB), .product(product)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int OP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              signedMode,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic              busy,
  input logic              done,
  input logic [2*OP_W-1:0] product
);
  logic [3:0] cycCnt;
  logic [3:0] expLat;
  logic       accept;

  assign accept = startIn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      expLat <= '0;
    end else if (accept) begin
      cycCnt <= 4'd1;
      expLat <= 4'd4 + {3'd0, signedMode & opA[OP_W-1]}
                     + {3'd0, signedMode & opB[OP_W-1]};
    end else if (busy) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_busy_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycCnt == expLat + 4'd1));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && done) |=> !busy);

  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done || (!busy && !startIn)) |=> $stable(product));

  assert_clear_on_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && product == '0));
endmodule

bind byte_serial_mul bsm_checker #(.OP_W(OP_W)) u_bsm_checker (
  .clk(clk), .rstN(rstN), .startIn(startIn), .signedMode(signedMode),
  .opA(opA), .opB(opB), .busy(busy), .done(done), .product(product)
);

// File: tb/tb_byte_serial_mul.sv
`timescale 1ns/1ps
module tb_byte_serial_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        signedMode = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        busy, done;
  logic [31:0] product;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  byte_serial_mul dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [31:0] refProd(logic [15:0] a, logic [15:0] b, logic sm);
    logic signed [31:0] sa, sb;
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    if (sm) return 32'(sa * sb);
    return {16'd0, a} * {16'd0, b};
  endfunction

  function automatic int refLat(logic [15:0] a, logic [15:0] b, logic sm);
    return 4 + ((sm && a[15]) ? 1 : 0) + ((sm && b[15]) ? 1 : 0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // holdStart: keep start high (with scrambled operands) through the done cycle
  task automatic runOp(logic [15:0] a, logic [15:0] b, logic sm, bit holdStart);
    int lat;
    logic [31:0] res;
    @(negedge clk);
    opA = a; opB = b; signedMode = sm; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lat = 0;
    check("R9 cleared on accept", product, 32'd0);
    if (holdStart) begin
      opA = ~a; opB = b ^ 16'h5A5A; signedMode = ~sm;
    end else begin
      startIn = 1'b0;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(sm ? "R2 signed product" : "R1 unsigned product", product, refProd(a, b, sm));
    check("R5 latency", 32'(lat), 32'(refLat(a, b, sm)));
    res = product;
    @(negedge clk);
    startIn = 1'b0;
    check("R4 done single pulse", {31'd0, done}, 32'd0);
    check("R3 no restart after done", {31'd0, busy}, 32'd0);
    check("R7 result held", product, res);
    @(negedge clk);
    check("R7 result held idle", product, res);
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset busy", {31'd0, busy}, 32'd0);
    check("R8 reset done", {31'd0, done}, 32'd0);
    check("R8 reset product", product, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners (R1, R2)
    runOp(16'h8000, 16'h8000, 1'b1, 1'b0);
    runOp(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    runOp(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    runOp(16'h8000, 16'hFFFF, 1'b1, 1'b0);
    runOp(16'h7FFF, 16'h8000, 1'b1, 1'b0);
    runOp(16'h8000, 16'h7FFF, 1'b1, 1'b0);
    runOp(16'h0000, 16'hFFFF, 1'b1, 1'b0);
    runOp(16'h8000, 16'h8000, 1'b0, 1'b0);

    // start held through busy and done with changing operands (R3, R6)
    runOp(16'hC3A5, 16'h8001, 1'b1, 1'b1);
    runOp(16'h1234, 16'hFEDC, 1'b0, 1'b1);

    // start while busy must not restart (R3)
    @(negedge clk);
    opA = 16'h0003; opB = 16'h0005; signedMode = 1'b0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    opA = 16'hFFFF; opB = 16'hFFFF; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    while (!done) @(negedge clk);
    check("R3 start while busy ignored", product, 32'd15);
    @(negedge clk);
    check("R3 idle after ignored start", {31'd0, busy}, 32'd0);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (i % 7 == 0) ra = 16'h8000;
      if (i % 5 == 0) rb = 16'hFFFF;
      runOp(ra, rb, 1'($urandom), (i % 4) == 3);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule